// File: doc/BRIEF.md
# Abstract Register Access Engine

This block sits inside a debug controller. A debugger writes an abstract command word through a simple register port, and the block turns it into a transfer between one 32-bit data register and a register of a halted hart. The hart side uses a valid/ready request that carries the register number, the direction, the access size and the write data. The hart answers with a one-cycle response strobe that carries read data and an error flag.

The block holds the command-status word, the data register and the state of the command in flight. It reports busy while a transfer is outstanding, and it keeps a 3-bit error code until the debugger clears it. Commands the block cannot carry out are rejected with an error and never start. These include quick access, program-buffer execution after a transfer, sizes other than 32 bits, and register numbers outside the supported windows. Reads on the register port are combinational from the address.

Top module: `absreg_engine`

## Requirements
- R1: After reset, busy and the error code are 0, the data register (address 0x04) reads 0, no request is raised, and the status word (address 0x16) reads 0x00000001: datacount 1 in bits 3:0, progsize 0 in bits 28:24, busy in bit 12, error code in bits 10:8.
- R2: A write to address 0x17 is accepted only when the block is idle, the error code is 0 and the hart is halted. It must also have type 0 in bits 31:24, postexec (bit 18) clear, transfer (bit 17) set, size (bits 22:20) equal to 2, and a supported register number in bits 15:0. An accepted command sets busy on the next cycle and raises the request. The request carries that register number, the write flag (bit 16) and the size, with the data register value as write data. All of these stay steady until the hart accepts.
- R3: For a read (bit 16 clear), the response data is copied into the data register on the response cycle, and busy drops on the following cycle.
- R4: For a write (bit 16 set), the data register keeps its value through and after the transfer.
- R5: A type-0 command with transfer clear and postexec clear finishes at once. It raises no request, sets no busy and sets no error, whatever its size and register number.
- R6: Type not 0, postexec set, or (with transfer set) a size other than 2 or an unsupported register number each set the error code to 2 without busy. Supported numbers are 0x0000–0x0FFF, 0x1000–0x101F and, when floating-point support is enabled, 0x1020–0x103F.
- R7: A supported command issued while the hart is not halted sets the error code to 4 and raises no request. The unsupported check of R6 takes priority.
- R8: A response with the error flag set makes the error code 3 and leaves the data register unchanged.
- R9: A write to the command or data register while busy is ignored. It sets the error code to 1 if the code was 0, and it never overwrites a nonzero code.
- R10: While the error code is nonzero, command writes are ignored and raise no request.
- R11: Writing 1s to bits 10:8 of address 0x16 clears those bits of the error code. A write that misses the set bits leaves the code as it was.
- R12: Address 0x17 and unmapped addresses read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWrEn | input | 1 | Register port write strobe |
| regAddr | input | 7 | Register port address |
| regWrData | input | 32 | Register port write data |
| regRdData | output | 32 | Register port read data for regAddr |
| hartHalted | input | 1 | Hart is halted |
| hartReqValid | output | 1 | Transfer request valid |
| hartReqReady | input | 1 | Hart accepts the request |
| hartReqRegno | output | 16 | Register number of the request |
| hartReqWrite | output | 1 | 1: write the hart register, 0: read it |
| hartReqSize | output | 3 | Access size code |
| hartReqWdata | output | 32 | Write data for the hart register |
| hartRspValid | input | 1 | Response strobe |
| hartRspRdata | input | 32 | Response read data |
| hartRspErr | input | 1 | Response reports an exception |

## Verification
The bench aims at the decode boundaries: the edges of the register-number windows (0x101F against 0x1040 and 0xC000), size 3 against size 2, and a transfer-clear command whose size and number are garbage. A design that decoded the windows loosely would start a transfer on a reserved number, and one that checked size without regard to transfer would report an error for a legal no-op. It also stalls the hart's ready for several cycles while it probes the block with writes. A design that let the data register or the request fields move during that stall would corrupt the hart write, and one that overwrote a pending error with the busy code would lose the first fault. Finally, it clears the error code bit by bit, which catches a clear that acts on the whole field or ignores the mask.

// File: rtl/absreg_pkg.sv
package absreg_pkg;
  localparam int ADDR_W = 7;
  localparam int DATA_W = 32;
  localparam logic [ADDR_W-1:0] ADDR_DATA0 = 7'h04;
  localparam logic [ADDR_W-1:0] ADDR_STAT  = 7'h16;
  localparam logic [ADDR_W-1:0] ADDR_CMD   = 7'h17;

  typedef enum logic [2:0] {
    ERR_NONE  = 3'd0,
    ERR_BUSY  = 3'd1,
    ERR_UNSUP = 3'd2,
    ERR_EXC   = 3'd3,
    ERR_HALT  = 3'd4,
    ERR_OTHER = 3'd7
  } cmdErrE;

  typedef enum logic [1:0] {ST_IDLE, ST_REQ, ST_RSP} ctrlStateE;

  typedef struct packed {
    logic cmdLatch;
    logic dataWr;
    logic rspCapture;
  } dpStrobeT;
endpackage

// File: rtl/absreg_ctrl.sv
module absreg_ctrl
  import absreg_pkg::*;
#(
  parameter bit HAS_FPR = 1'b1,
  parameter int GPR_COUNT = 32,
  parameter int FPR_COUNT = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [DATA_W-1:0] regWrData,
  input  logic              hartHalted,
  input  logic              hartReqReady,
  input  logic              hartRspValid,
  input  logic              hartRspErr,
  output logic              busy,
  output logic [2:0]        cmdErr,
  output logic              hartReqValid,
  output dpStrobeT          strobe
);
  localparam logic [2:0]  ACC_SIZE = 3'($clog2(DATA_W / 8));
  localparam logic [15:0] GPR_BASE = 16'h1000;
  localparam logic [15:0] GPR_LAST = 16'(GPR_BASE + GPR_COUNT - 1);
  localparam logic [15:0] FPR_BASE = 16'(GPR_BASE + GPR_COUNT);
  localparam logic [15:0] FPR_LAST = 16'(FPR_BASE + FPR_COUNT - 1);

  ctrlStateE state, stateNext;
  logic [2:0] errNext;
  logic cmdWr, dataWrReq, statWr, unsup, launch, regnoOk;
  logic [7:0] cmdType;
  logic [15:0] regno;

  assign cmdType = regWrData[31:24];
  assign regno   = regWrData[15:0];
  assign busy    = (state != ST_IDLE);
  assign hartReqValid = (state == ST_REQ);

  always_comb begin
    cmdWr     = regWrEn && (regAddr == ADDR_CMD);
    dataWrReq = regWrEn && (regAddr == ADDR_DATA0);
    statWr    = regWrEn && (regAddr == ADDR_STAT);
    regnoOk   = (regno < GPR_BASE) || (regno >= GPR_BASE && regno <= GPR_LAST)
              || (HAS_FPR && regno >= FPR_BASE && regno <= FPR_LAST);
    unsup     = (cmdType != 8'd0) || regWrData[18]
              || (regWrData[17] && ((regWrData[22:20] != ACC_SIZE) || !regnoOk));
    launch    = cmdWr && !busy && (cmdErr == ERR_NONE) && !unsup
              && regWrData[17] && hartHalted;
    strobe.cmdLatch   = launch;
    strobe.dataWr     = dataWrReq && !busy;
    strobe.rspCapture = (state == ST_RSP) && hartRspValid && !hartRspErr;
  end

  always_comb begin
    stateNext = state;
    case (state)
      ST_IDLE: if (launch) stateNext = ST_REQ;
      ST_REQ:  if (hartReqReady) stateNext = ST_RSP;
      ST_RSP:  if (hartRspValid) stateNext = ST_IDLE;
      default: stateNext = ST_IDLE;
    endcase
  end

  always_comb begin
    errNext = cmdErr;
    if (statWr) errNext = cmdErr & ~regWrData[10:8];
    if (busy && (cmdWr || dataWrReq) && cmdErr == ERR_NONE) errNext = ERR_BUSY;
    else if (cmdWr && !busy && cmdErr == ERR_NONE) begin
      if (unsup) errNext = ERR_UNSUP;
      else if (regWrData[17] && !hartHalted) errNext = ERR_HALT;
    end
    if (state == ST_RSP && hartRspValid && hartRspErr && errNext == ERR_NONE)
      errNext = ERR_EXC;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state  <= ST_IDLE;
      cmdErr <= ERR_NONE;
    end else begin
      state  <= stateNext;
      cmdErr <= errNext;
    end
  end
endmodule

// File: rtl/absreg_datapath.sv
module absreg_datapath
  import absreg_pkg::*;
#(
  parameter int DATA_COUNT = 1,
  parameter int PROG_SIZE = 0
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobeT          strobe,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [DATA_W-1:0] regWrData,
  input  logic [DATA_W-1:0] hartRspRdata,
  input  logic              busy,
  input  logic [2:0]        cmdErr,
  output logic [DATA_W-1:0] regRdData,
  output logic [15:0]       hartReqRegno,
  output logic              hartReqWrite,
  output logic [2:0]        hartReqSize,
  output logic [DATA_W-1:0] hartReqWdata
);
  logic [DATA_W-1:0] data0;
  logic [15:0] regnoQ;
  logic writeQ;
  logic [2:0] sizeQ;
  logic [31:0] statWord;

  assign hartReqRegno = regnoQ;
  assign hartReqWrite = writeQ;
  assign hartReqSize  = sizeQ;
  assign hartReqWdata = data0;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      data0  <= '0;
      regnoQ <= '0;
      writeQ <= 1'b0;
      sizeQ  <= '0;
    end else begin
      if (strobe.dataWr) data0 <= regWrData;
      if (strobe.rspCapture && !writeQ) data0 <= hartRspRdata;
      if (strobe.cmdLatch) begin
        regnoQ <= regWrData[15:0];
        writeQ <= regWrData[16];
        sizeQ  <= regWrData[22:20];
      end
    end
  end

  always_comb begin
    statWord = {3'b0, 5'(PROG_SIZE), 11'b0, busy, 1'b0, cmdErr, 4'b0, 4'(DATA_COUNT)};
    case (regAddr)
      ADDR_DATA0: regRdData = data0;
      ADDR_STAT:  regRdData = statWord;
      default:    regRdData = '0;
    endcase
  end
endmodule

// File: rtl/absreg_engine.sv
module absreg_engine
  import absreg_pkg::*;
#(
  parameter bit HAS_FPR = 1'b1,
  parameter int GPR_COUNT = 32,
  parameter int FPR_COUNT = 32
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        regWrEn,
  input  logic [6:0]  regAddr,
  input  logic [31:0] regWrData,
  output logic [31:0] regRdData,
  input  logic        hartHalted,
  output logic        hartReqValid,
  input  logic        hartReqReady,
  output logic [15:0] hartReqRegno,
  output logic        hartReqWrite,
  output logic [2:0]  hartReqSize,
  output logic [31:0] hartReqWdata,
  input  logic        hartRspValid,
  input  logic [31:0] hartRspRdata,
  input  logic        hartRspErr
);
  logic busy;
  logic [2:0] cmdErr;
  dpStrobeT strobe;

  absreg_ctrl #(.HAS_FPR(HAS_FPR), .GPR_COUNT(GPR_COUNT), .FPR_COUNT(FPR_COUNT)) ctrl_i (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .hartHalted(hartHalted), .hartReqReady(hartReqReady),
    .hartRspValid(hartRspValid), .hartRspErr(hartRspErr), .busy(busy),
    .cmdErr(cmdErr), .hartReqValid(hartReqValid), .strobe(strobe)
  );

  absreg_datapath #(.DATA_COUNT(1), .PROG_SIZE(0)) dp_i (
    .clk(clk), .rstN(rstN), .strobe(strobe), .regAddr(regAddr),
    .regWrData(regWrData), .hartRspRdata(hartRspRdata), .busy(busy),
    .cmdErr(cmdErr), .regRdData(regRdData), .hartReqRegno(hartReqRegno),
    .hartReqWrite(hartReqWrite), .hartReqSize(hartReqSize),
    .hartReqWdata(hartReqWdata)
  );
endmodule

// File: rtl/absreg_engine_chk.sv
module absreg_engine_chk (
  input logic        clk,
  input logic        rstN,
  input logic        regWrEn,
  input logic [6:0]  regAddr,
  input logic        hartHalted,
  input logic        hartReqValid,
  input logic        hartReqReady,
  input logic [15:0] hartReqRegno,
  input logic [31:0] hartReqWdata,
  input logic        hartRspValid,
  input logic        busy,
  input logic [2:0]  cmdErr
);
  // R2: request fields hold while the hart stalls
  a_r2_req_hold: assert property (@(posedge clk) disable iff (!rstN)
    hartReqValid && !hartReqReady |=> hartReqValid && $stable(hartReqRegno) && $stable(hartReqWdata));
  // R2: a request is only raised while busy
  a_r2_req_busy: assert property (@(posedge clk) disable iff (!rstN)
    hartReqValid |-> busy);
  // R7: a transfer only starts with the hart halted
  a_r7_start_halted: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> $past(hartHalted));
  // R3: busy drops after the response
  a_r3_busy_clears: assert property (@(posedge clk) disable iff (!rstN)
    busy && !hartReqValid && hartRspValid |=> !busy);
  // R10: no new request starts from a nonzero error code
  a_r10_err_blocks: assert property (@(posedge clk) disable iff (!rstN)
    $rose(hartReqValid) |-> $past(cmdErr) == 3'd0);
  // R11: a nonzero code only changes by a status write
  a_r11_sticky: assert property (@(posedge clk) disable iff (!rstN)
    cmdErr != 3'd0 && !(regWrEn && regAddr == 7'h16) |=> cmdErr == $past(cmdErr));
  // R6: only defined codes appear
  a_r6_legal_code: assert property (@(posedge clk) disable iff (!rstN)
    cmdErr <= 3'd4);
endmodule

bind absreg_engine absreg_engine_chk chk_i (
  .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
  .hartHalted(hartHalted), .hartReqValid(hartReqValid), .hartReqReady(hartReqReady),
  .hartReqRegno(hartReqRegno), .hartReqWdata(hartReqWdata),
  .hartRspValid(hartRspValid), .busy(busy), .cmdErr(cmdErr)
);

// File: tb/absreg_engine_tb_top.sv
`timescale 1ns/1ps
module absreg_engine_tb_top;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic regWrEn = 1'b0;
  logic [6:0] regAddr = '0;
  logic [31:0] regWrData = '0;
  logic [31:0] regRdData;
  logic hartHalted = 1'b1;
  logic hartReqValid;
  logic hartReqReady = 1'b0;
  logic [15:0] hartReqRegno;
  logic hartReqWrite;
  logic [2:0] hartReqSize;
  logic [31:0] hartReqWdata;
  logic hartRspValid = 1'b0;
  logic [31:0] hartRspRdata = '0;
  logic hartRspErr = 1'b0;
  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  absreg_engine dut_i (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .regRdData(regRdData), .hartHalted(hartHalted),
    .hartReqValid(hartReqValid), .hartReqReady(hartReqReady),
    .hartReqRegno(hartReqRegno), .hartReqWrite(hartReqWrite),
    .hartReqSize(hartReqSize), .hartReqWdata(hartReqWdata),
    .hartRspValid(hartRspValid), .hartRspRdata(hartRspRdata),
    .hartRspErr(hartRspErr)
  );

  // {command, halted, expected error code, expect request}
  localparam logic [36:0] VEC [12] = '{
    {32'h0022_1008, 1'b1, 3'd0, 1'b1},
    {32'h0023_1005, 1'b1, 3'd0, 1'b1},
    {32'h0022_07B1, 1'b1, 3'd0, 1'b1},
    {32'h0022_101F, 1'b1, 3'd0, 1'b1},
    {32'h0023_1025, 1'b1, 3'd0, 1'b1},
    {32'h0070_C000, 1'b1, 3'd0, 1'b0},
    {32'h0100_0000, 1'b1, 3'd2, 1'b0},
    {32'h0026_1008, 1'b1, 3'd2, 1'b0},
    {32'h0032_1008, 1'b1, 3'd2, 1'b0},
    {32'h0022_C000, 1'b1, 3'd2, 1'b0},
    {32'h0022_1040, 1'b1, 3'd2, 1'b0},
    {32'h0022_1008, 1'b0, 3'd4, 1'b0}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic regWr(input logic [6:0] a, input logic [31:0] d);
    @(negedge clk);
    regWrEn = 1'b1; regAddr = a; regWrData = d;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic regRd(input logic [6:0] a, output logic [31:0] d);
    regAddr = a;
    #1;
    d = regRdData;
  endtask

  task automatic serve(input logic [31:0] rd, input logic err);
    hartReqReady = 1'b1;
    @(negedge clk);
    hartReqReady = 1'b0;
    hartRspValid = 1'b1; hartRspRdata = rd; hartRspErr = err;
    @(negedge clk);
    hartRspValid = 1'b0; hartRspErr = 1'b0;
  endtask

  task automatic finishRun();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    finishRun();
  end

  initial begin
    logic [31:0] rd;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    regRd(7'h16, rd); chk("R1 status", rd, 32'h0000_0001);
    regRd(7'h04, rd); chk("R1 data0", rd, 32'h0);
    chk("R1 req", {31'b0, hartReqValid}, 32'h0);

    // vector table: R2-R7
    for (int i = 0; i < 12; i++) begin
      logic [31:0] cmd, pre;
      logic [2:0] eErr;
      logic eReq;
      {cmd, hartHalted, eErr, eReq} = VEC[i];
      pre = 32'h1234_0000 + 32'(i);
      regWr(7'h16, 32'h0000_0700);
      regWr(7'h04, pre);
      regWr(7'h17, cmd);
      regRd(7'h16, rd);
      chk($sformatf("R6/R7 vec%0d cmderr", i), {29'b0, rd[10:8]}, {29'b0, eErr});
      chk($sformatf("R2/R5 vec%0d busy", i), {31'b0, rd[12]}, {31'b0, eReq});
      chk($sformatf("R2/R5 vec%0d req", i), {31'b0, hartReqValid}, {31'b0, eReq});
      if (eReq) begin
        chk($sformatf("R2 vec%0d fields", i),
            {hartReqRegno, 12'b0, hartReqWrite, hartReqSize},
            {cmd[15:0], 12'b0, cmd[16], cmd[22:20]});
        chk($sformatf("R2 vec%0d wdata", i), hartReqWdata, pre);
        serve(32'hA500_0000 + 32'(i), 1'b0);
        regRd(7'h16, rd); chk($sformatf("R3 vec%0d idle", i), rd, 32'h0000_0001);
        regRd(7'h04, rd);
        if (cmd[16]) chk($sformatf("R4 vec%0d data0", i), rd, pre);
        else chk($sformatf("R3 vec%0d data0", i), rd, 32'hA500_0000 + 32'(i));
      end else begin
        regRd(7'h04, rd); chk($sformatf("R6 vec%0d data0", i), rd, pre);
      end
    end
    hartHalted = 1'b1;
    regWr(7'h16, 32'h0000_0700);

    // R2 stall, R9 writes while busy
    regWr(7'h04, 32'hCAFE_0001);
    regWr(7'h17, 32'h0023_1003);
    repeat (3) @(negedge clk);
    chk("R2 stall valid", {31'b0, hartReqValid}, 32'h1);
    chk("R2 stall regno", {16'b0, hartReqRegno}, 32'h1003);
    regWr(7'h04, 32'h1111_1111);
    regRd(7'h16, rd); chk("R9 busy code", {29'b0, rd[10:8]}, 32'h1);
    chk("R9 wdata held", hartReqWdata, 32'hCAFE_0001);
    regWr(7'h17, 32'h0022_1001);
    chk("R9 regno held", {16'b0, hartReqRegno}, 32'h1003);
    serve(32'hDEAD_BEEF, 1'b1);
    regRd(7'h16, rd); chk("R9 code kept", {29'b0, rd[10:8]}, 32'h1);
    regRd(7'h04, rd); chk("R4 data0 kept", rd, 32'hCAFE_0001);

    // R10 ignored while error pending
    regWr(7'h17, 32'h0022_1001);
    chk("R10 no req", {31'b0, hartReqValid}, 32'h0);
    regRd(7'h16, rd); chk("R10 idle", {19'b0, rd[12:0]}, 32'h0000_0101);

    // R11 partial clears
    regWr(7'h16, 32'h0000_0100);
    regRd(7'h16, rd); chk("R11 clear", {29'b0, rd[10:8]}, 32'h0);
    hartHalted = 1'b0;
    regWr(7'h17, 32'h0022_1001);
    hartHalted = 1'b1;
    regWr(7'h16, 32'h0000_0300);
    regRd(7'h16, rd); chk("R11 masked keep", {29'b0, rd[10:8]}, 32'h4);
    regWr(7'h16, 32'h0000_0400);
    regRd(7'h16, rd); chk("R11 masked clear", {29'b0, rd[10:8]}, 32'h0);

    // R8 exception response
    regWr(7'h04, 32'h0000_0055);
    regWr(7'h17, 32'h0022_1002);
    serve(32'hFFFF_FFFF, 1'b1);
    regRd(7'h16, rd); chk("R8 code", {29'b0, rd[10:8]}, 32'h3);
    regRd(7'h04, rd); chk("R8 data0", rd, 32'h0000_0055);

    // R12 reads
    regRd(7'h17, rd); chk("R12 cmd reads 0", rd, 32'h0);
    regRd(7'h10, rd); chk("R12 unmapped", rd, 32'h0);

    finishRun();
  end
endmodule